// File: doc/BRIEF.md
# 64-bit Snapshot Counter

This block is a free-running 64-bit up-counter on a 32-bit register bus. It runs from its clock through a programmable divider. Software reads it without tearing by asking for a snapshot: a single control write copies the full count into a pair of latched words. Software then reads those words at leisure while the live count moves on. Software can also preset the count. It writes two 32-bit preload words, then issues a control write that moves both words into the counter in one cycle.

The register bus is plain control traffic with no back-pressure. A read strobe is accepted in every cycle. The read data is registered and is valid in the cycle after the strobe, then holds until the next read. A write strobe takes effect at the clock edge where it is sampled. The usual start-up is a write of zero to the control register and to both preload words, then a load trigger, so counting begins from zero at full rate.

Top module: `snap_counter64`

## Requirements
- R1: Registers sit at these byte offsets: control 0x68, live low 0x6C, live high 0x70, preload low 0x74, preload high 0x78, latched low 0x7C, latched high 0x80. A read strobe returns the addressed register on `reg_rdata` after the next clock edge, and that value is the state from before the edge. Every other offset reads as zero.
- R2: A control write with bits [1:0] = 2'b01 copies the 64-bit count, as it stood before that edge, into the latched low and high words. The latched words keep that value until the next such write.
- R3: A control write with bits [1:0] = 2'b11 moves {preload high, preload low} into the counter. If an increment falls due in the same cycle, the load takes priority.
- R4: The divider field is control bits [15:8]. With value N the count advances once every N+1 clocks. A load restarts the divider phase, so the first advance after a load edge W lands on edge W+N+1. A value of 0 advances the count on every clock.
- R5: The count wraps modulo 2^64, and the carry passes from the low word into the high word.
- R6: Trigger bits [1:0] are self-clearing. A control read returns the divider in bits [15:8] and zero in all other bits. Pattern 2'b10 neither loads nor latches.
- R7: After reset the divider is 0, the counter starts from 0 and advances on every clock, and the preload and latched words read zero.
- R8: The preload words read back as written. Writing them does not change the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | WORD_W (32) | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | WORD_W (32) | Registered read data, valid the cycle after `reg_rd` |

## Verification
The bench sweeps several divider values and every load-to-latch distance up to two divider periods. It checks each snapshot against an arithmetic model of edges since the load. A divider that does not restart on load, or that counts N instead of N+1 clocks, gives off-by-one snapshots. A latch that samples the count after the edge does the same. Separate cases check the 64-bit wrap, the carry from the low word into the high word, and that the 2'b10 pattern and preload writes leave the count alone. A design that let the trigger bits stick, or that reloaded on a preload write, would show it in the control readback or in the live word.

// File: rtl/snap_counter64_pkg.sv
`timescale 1ns/1ps
package snap_counter64_pkg;
  // Register byte offsets (software decodes these)
  localparam logic [7:0] OFS_CTRL    = 8'h68;
  localparam logic [7:0] OFS_LIVE_LO = 8'h6C;
  localparam logic [7:0] OFS_LIVE_HI = 8'h70;
  localparam logic [7:0] OFS_LOAD_LO = 8'h74;
  localparam logic [7:0] OFS_LOAD_HI = 8'h78;
  localparam logic [7:0] OFS_SNAP_LO = 8'h7C;
  localparam logic [7:0] OFS_SNAP_HI = 8'h80;

  // Control field positions
  localparam int DIV_LSB = 8;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'b00,
    TRIG_SNAP  = 2'b01,
    TRIG_INERT = 2'b10,
    TRIG_LOAD  = 2'b11
  } trig_e;
endpackage

// File: rtl/snap_prescaler.sv
`timescale 1ns/1ps
module snap_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] phase_q;

  // A divider lowered below the current phase fires at once instead of wrapping.
  assign tick_o = (phase_q >= div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart_i || tick_o) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // R4: straight after a restart, a tick is due only when the divider is zero
  a_r4_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (tick_o == (div_i == '0)));
endmodule

// File: rtl/snap_count_core.sv
`timescale 1ns/1ps
module snap_count_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R3: a load replaces the count even when a tick is due
  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_o == $past(load_val_i)));
  // R5: an increment wraps modulo 2^CNT_W
  a_r5_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
  // R5: no tick, no load, no change
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(cnt_o));
endmodule

// File: rtl/snap_regs.sv
`timescale 1ns/1ps
module snap_regs
  import snap_counter64_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [WORD_W-1:0]   reg_wdata,
  input  logic                reg_rd,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [2*WORD_W-1:0] cnt_i,
  output logic [DIV_W-1:0]    div_o,
  output logic                load_go_o,
  output logic [2*WORD_W-1:0] load_val_o
);
  localparam int CNT_W = 2 * WORD_W;
  localparam int NWORD = 2;

  logic [DIV_W-1:0]  div_q;
  logic [WORD_W-1:0] pre_q  [NWORD];
  logic [CNT_W-1:0]  snap_q;
  logic              ctrl_hit;
  trig_e             trig;
  logic              snap_go;
  logic [WORD_W-1:0] rd_mux;

  assign ctrl_hit  = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  assign trig      = trig_e'(reg_wdata[1:0]);
  assign snap_go   = ctrl_hit && (trig == TRIG_SNAP);
  assign load_go_o = ctrl_hit && (trig == TRIG_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (ctrl_hit) begin
      div_q <= reg_wdata[DIV_LSB +: DIV_W];
    end
  end
  assign div_o = div_q;

  // Preload words, one register per half
  for (genvar h = 0; h < NWORD; h++) begin : g_pre
    localparam logic [ADDR_W-1:0] OFS_H = ADDR_W'(OFS_LOAD_LO) + ADDR_W'(4 * h);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_q[h] <= '0;
      end else if (reg_wr && (reg_addr == OFS_H)) begin
        pre_q[h] <= reg_wdata;
      end
    end
    assign load_val_o[h*WORD_W +: WORD_W] = pre_q[h];
  end

  // Snapshot: whole count in one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_go) begin
      snap_q <= cnt_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(OFS_CTRL):    rd_mux = WORD_W'(div_q) << DIV_LSB;
      ADDR_W'(OFS_LIVE_LO): rd_mux = cnt_i[WORD_W-1:0];
      ADDR_W'(OFS_LIVE_HI): rd_mux = cnt_i[CNT_W-1:WORD_W];
      ADDR_W'(OFS_LOAD_LO): rd_mux = pre_q[0];
      ADDR_W'(OFS_LOAD_HI): rd_mux = pre_q[1];
      ADDR_W'(OFS_SNAP_LO): rd_mux = snap_q[WORD_W-1:0];
      ADDR_W'(OFS_SNAP_HI): rd_mux = snap_q[CNT_W-1:WORD_W];
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
    end
  end

  // R2: snapshot takes the pre-edge count
  a_r2_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
    snap_go |=> ({reg_rdata, snap_q} == {reg_rdata, $past(cnt_i)}));
  // R2: snapshot words hold between triggers
  a_r2_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_go |=> $stable(snap_q));
  // R6: trigger bits never read back
  a_r6_trig_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(OFS_CTRL)) |=> (reg_rdata[1:0] == 2'b00));
  // R6: load and snapshot are exclusive
  a_r6_trig_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snap_go, load_go_o}));
endmodule

// File: rtl/snap_counter64.sv
`timescale 1ns/1ps
module snap_counter64 #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [WORD_W-1:0] reg_rdata
);
  localparam int CNT_W = 2 * WORD_W;

  logic [DIV_W-1:0] div;
  logic             load_go;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  snap_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DIV_W(DIV_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .cnt_i      (cnt),
    .div_o      (div),
    .load_go_o  (load_go),
    .load_val_o (load_val)
  );

  snap_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_i     (div),
    .restart_i (load_go),
    .tick_o    (tick)
  );

  snap_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .load_i     (load_go),
    .load_val_i (load_val),
    .cnt_o      (cnt)
  );

  // R4: with divider zero and no load, every clock advances the count
  a_r4_div0_every: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0 && !load_go) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/snap_counter64_tb.sv
`timescale 1ns/1ps
module snap_counter64_tb;
  localparam logic [7:0] A_CTRL = 8'h68, A_LLO = 8'h6C, A_LHI = 8'h70,
                         A_PLO = 8'h74, A_PHI = 8'h78, A_SLO = 8'h7C, A_SHI = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails = 0;
  int edge_n = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  snap_counter64 u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int e);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    e = edge_n;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output int e);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    e = edge_n;
  endtask

  // Count after edge e, given a load of v with divider n at edge w
  function automatic logic [63:0] expc(input logic [63:0] v, input int w, input int n, input int e);
    return v + 64'((e - w) / (n + 1));
  endfunction

  task automatic load64(input logic [63:0] v, input int n, output int w);
    int t;
    wr(A_PLO, v[31:0], t);
    wr(A_PHI, v[63:32], t);
    wr(A_CTRL, 32'((n << 8) | 3), w);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [63:0] v, snap;
    int e, e2, w, l;
    int divs[4] = '{0, 1, 2, 5};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    rd(A_CTRL, d, e); chk("R7 ctrl after reset", 64'(d), 64'h0);
    rd(A_SLO, d, e);  chk("R7 snap lo after reset", 64'(d), 64'h0);
    rd(A_SHI, d, e);  chk("R7 snap hi after reset", 64'(d), 64'h0);
    rd(A_PLO, d, e);  chk("R7 preload lo after reset", 64'(d), 64'h0);
    rd(A_PHI, d, e);  chk("R7 preload hi after reset", 64'(d), 64'h0);
    rd(A_LLO, d, e);
    rd(A_LLO, d2, e2);
    chk("R7 counts each clock", 64'(d2 - d), 64'(e2 - e));

    // R1 unmapped offsets
    rd(8'h00, d, e); chk("R1 unmapped 0x00", 64'(d), 64'h0);
    rd(8'h84, d, e); chk("R1 unmapped 0x84", 64'(d), 64'h0);

    // R2 R3 R4 sweep over divider and load-to-snapshot distance
    foreach (divs[i]) begin
      int n = divs[i];
      for (int k = 0; k <= 2 * (n + 1); k++) begin
        v = {32'h1000_0000 + 32'(i), 32'hFFFF_FF00 + 32'(k)};
        load64(v, n, w);
        repeat (k) @(negedge clk);
        wr(A_CTRL, 32'((n << 8) | 1), l);
        rd(A_SLO, d, e);
        rd(A_SHI, d2, e);
        chk($sformatf("R2 R4 snapshot n=%0d k=%0d", n, k), {d2, d}, expc(v, w, n, l - 1));
        rd(A_LLO, d, e);
        chk($sformatf("R3 R4 live lo n=%0d k=%0d", n, k), 64'(d), 64'(expc(v, w, n, e - 1) & 64'hFFFF_FFFF));
        rd(A_LHI, d, e);
        chk($sformatf("R1 live hi n=%0d k=%0d", n, k), 64'(d), expc(v, w, n, e - 1) >> 32);
      end
    end

    // R5 full 64-bit wrap
    v = 64'hFFFF_FFFF_FFFF_FFFE;
    load64(v, 0, w);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 32'h1, l);
    rd(A_SLO, d, e); rd(A_SHI, d2, e);
    chk("R5 wrap through zero", {d2, d}, expc(v, w, 0, l - 1));

    // R5 carry low to high with divider 1
    v = 64'h0000_0001_FFFF_FFFF;
    load64(v, 1, w);
    repeat (4) @(negedge clk);
    wr(A_CTRL, 32'h0000_0101, l);
    rd(A_SLO, d, e); rd(A_SHI, d2, e);
    chk("R5 carry into high word", {d2, d}, expc(v, w, 1, l - 1));

    // R6 R8 inert pattern and preload writes leave the count alone
    v = 64'h0000_0005_0000_0100;
    load64(v, 0, w);
    wr(A_CTRL, 32'h1, l);
    snap = expc(v, w, 0, l - 1);
    wr(A_PLO, 32'hDEAD_0001, e);
    wr(A_PHI, 32'hBEEF_0002, e);
    wr(A_CTRL, 32'h2, e);
    rd(A_LLO, d, e);
    chk("R6 R8 no reload on 2'b10 or preload write", 64'(d), 64'(expc(v, w, 0, e - 1) & 64'hFFFF_FFFF));
    rd(A_LHI, d, e);
    chk("R6 live hi unchanged", 64'(d), 64'h5);
    rd(A_SLO, d, e);
    chk("R2 snapshot held", 64'(d), 64'(snap & 64'hFFFF_FFFF));
    rd(A_CTRL, d, e);
    chk("R6 ctrl reads divider only", 64'(d), 64'h0);
    rd(A_PLO, d, e);
    chk("R8 preload lo readback", 64'(d), 64'hDEAD_0001);
    rd(A_PHI, d, e);
    chk("R8 preload hi readback", 64'(d), 64'hBEEF_0002);

    // R6 divider readback with triggers cleared
    wr(A_CTRL, 32'h0000_0703, e);
    rd(A_CTRL, d, e);
    chk("R6 ctrl readback after load", 64'(d), 64'h700);
    wr(A_CTRL, 32'h0000_0000, e);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule